// File: doc/BRIEF.md
# Jittered PWM Switching Timebase

This block sets the switching rhythm of a current-mode power converter controller. A free-running counter marks off switching periods. At the start of each period the counter reloads from a nominal period, which a two-bit option input chooses among three switching frequencies. A slow triangular offset moves that reload value up and down. This spreads the switching energy across neighbouring frequencies, so the conducted emission peaks are lower.

The same counter also produces the two on-time windows. The first is a blanking window at the start of every period: during it a current-limit turn-off request is not accepted, which gives a minimum on-time. The second is a forced turn-off point at a fixed fraction of whichever period is currently running. When that forced turn-off ends the on-time, rather than an external current-limit request, a flag marks the cycle for the rest of the controller. Comparators, sensing and gate drive sit outside this block. It provides only the timing that they act on.

Top module: `swt_timebase`

## Requirements
- R1: While reset is held, and afterwards while enable stays low, all four outputs stay low.
- R2: The first cycle-start pulse appears in the clock cycle right after enable is sampled high. The first period after that lasts exactly the nominal length P = CLK_HZ / (F_LOW_HZ << i). Here i is 0, 1 or 2 for select codes 2'b00 (low), 2'b01 (mid) and 2'b10 (high).
- R3: Every period length stays within Pn − S·STEP to Pn + S·STEP. S is JIT_STEPS and STEP = floor(Pn·JIT_PCT / (100·S)).
- R4: The jitter index moves one step every CLK_HZ/(JIT_HZ·4·S) clocks in a triangular up/down pattern. Two successive periods therefore differ by a whole multiple of STEP, and within one sweep of CLK_HZ/JIT_HZ clocks both extreme lengths occur.
- R5: If no current-limit request has ended the on-time, the max-duty turn-off pulse is high for exactly one clock. It falls at offset floor(P·DUTY_NUM / 2^DUTY_SHIFT) clocks after the cycle-start clock of a period of length P.
- R6: The blanking output is high for exactly TON = ceil(TON_MIN_NS·CLK_HZ / 10^9) consecutive clocks, starting with the cycle-start clock.
- R7: A current-limit request sampled while blanking is low ends the on-time. No max-duty pulse follows in that period, and the flag stays low.
- R8: A current-limit request sampled while blanking is high is ignored, and the max-duty pulse still fires at its usual offset.
- R9: The max-duty flag rises the clock after the max-duty pulse and stays high until the end of the period. It is low in the cycle-start clock.
- R10: From the clock after enable is sampled low, all outputs stay low. On re-enable the jitter restarts from zero, so the first period again has the nominal length.
- R11: A change of the select input does not affect the period already running. It takes effect at the next cycle start. Code 2'b11 behaves as the low option.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsel_i | input | 2 | Switching frequency option select |
| en_i | input | 1 | Run enable; low stops switching and clears jitter |
| cl_off_i | input | 1 | Current-limit turn-off request for the running on-time |
| start_o | output | 1 | One-clock pulse at the start of each switching period |
| dutyoff_o | output | 1 | One-clock pulse at the maximum-duty turn-off point |
| blank_o | output | 1 | Minimum on-time window after each cycle start |
| dmax_o | output | 1 | The current period's on-time was ended by the duty limit |

## Verification
All outputs are combinational decodes of registered state. The bench samples them on the falling edge, midway between two active edges. Its reference point is the clock in which start is seen, one clock after enable is sampled high. From that clock it measures period length, pulse offset, blanking length and flag shape. It finalises those figures for a period only when the next start arrives, so a period that has not yet ended is never judged. Current-limit requests and select changes are driven on a falling edge, at a known offset from a start. Their effect is therefore due at the next rising edge, or at the next period boundary for a select change.

// File: rtl/swt_pkg.sv
// Shared types and helpers for the switching timebase.
// Assumes exactly three frequency options, each double the one before.
package swt_pkg;

    typedef enum logic [1:0] {
        FOPT_LOW  = 2'b00,
        FOPT_MID  = 2'b01,
        FOPT_HIGH = 2'b10,
        FOPT_RSV  = 2'b11
    } fopt_e;

    localparam int NUM_OPT = 3;

    // Map a select code to an option index; the reserved code falls back to low.
    function automatic logic [1:0] opt_index(input logic [1:0] sel);
        return (sel == FOPT_RSV) ? 2'd0 : sel;
    endfunction

endpackage

// File: rtl/swt_jitter.sv
// Triangular jitter index generator.
// The index walks 0 -> +S -> -S -> 0, one step every DWELL clocks. While run_i
// is low it is held at zero, heading up, so each enable starts a fresh sweep.
module swt_jitter #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int JIT_HZ    = 260,
    parameter int JIT_STEPS = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       run_i,
    output logic signed [$clog2(JIT_STEPS+1):0]        k_o
);
    localparam int KW        = $clog2(JIT_STEPS+1) + 1;
    localparam int DWELL_RAW = CLK_HZ / (JIT_HZ * 4 * JIT_STEPS);
    localparam int DWELL     = (DWELL_RAW < 1) ? 1 : DWELL_RAW;
    localparam int DWW       = $clog2(DWELL + 1);
    localparam logic signed [KW-1:0] KMAX = KW'(JIT_STEPS);
    localparam logic signed [KW-1:0] KMIN = -KMAX;
    localparam logic signed [KW-1:0] KONE = KW'(1);

    logic signed [KW-1:0] k_q;
    logic                 up_q;
    logic [DWW-1:0]       dw_q;

    // Advance the dwell timer and step the triangle on its wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            k_q  <= '0;
            up_q <= 1'b1;
            dw_q <= '0;
        end else if (dw_q == DWW'(DWELL - 1)) begin
            dw_q <= '0;
            if (up_q) begin
                if (k_q == KMAX) begin
                    up_q <= 1'b0;
                    k_q  <= k_q - KONE;
                end else begin
                    k_q <= k_q + KONE;
                end
            end else begin
                if (k_q == KMIN) begin
                    up_q <= 1'b1;
                    k_q  <= k_q + KONE;
                end else begin
                    k_q <= k_q - KONE;
                end
            end
        end else begin
            dw_q <= dw_q + DWW'(1);
        end
    end

    assign k_o = k_q;

    // R3: the index never leaves the permitted swing.
    assert_k_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (k_q <= KMAX) && (k_q >= KMIN));

    // R4: while running, the index only ever moves by one step.
    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && (k_q != $past(k_q))) |->
            ((k_q == $past(k_q) + KONE) || (k_q == $past(k_q) - KONE)));

endmodule

// File: rtl/swt_period.sv
// Period and duty-point calculator.
// Combinational. It takes the option select and the jitter index and returns
// the reload length and the forced turn-off offset for the next period.
// Assumes DUTY_NUM < 2**DUTY_SHIFT and a swing well below the nominal period.
module swt_period
    import swt_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int F_LOW_HZ   = 30_000,
    parameter int JIT_STEPS  = 8,
    parameter int JIT_PCT    = 7,
    parameter int DUTY_NUM   = 96,
    parameter int DUTY_SHIFT = 7
) (
    input  logic [1:0]                                 fsel_i,
    input  logic signed [$clog2(JIT_STEPS+1):0]        k_i,
    output logic [$clog2(CLK_HZ/F_LOW_HZ + 1):0]       period_o,
    output logic [$clog2(CLK_HZ/F_LOW_HZ + 1):0]       toff_o
);
    localparam int PW  = $clog2(CLK_HZ/F_LOW_HZ + 1) + 1;
    localparam int KW  = $clog2(JIT_STEPS+1) + 1;
    localparam int SW  = PW + 2;
    localparam int PPW = PW + DUTY_SHIFT;

    logic [PW-1:0] pn_arr [NUM_OPT];
    logic [PW-1:0] st_arr [NUM_OPT];

    // One nominal length and jitter step per frequency option.
    for (genvar g = 0; g < NUM_OPT; g++) begin : g_opt
        localparam int PN   = CLK_HZ / (F_LOW_HZ << g);
        localparam int STEP = (PN * JIT_PCT) / (100 * JIT_STEPS);
        assign pn_arr[g] = PW'(PN);
        assign st_arr[g] = PW'(STEP);
    end

    logic [1:0]           idx;
    logic signed [SW-1:0] kx, pnx, stx, sum;
    logic [PPW-1:0]       prod;

    // Offset the nominal length by index times step, then scale for the duty point.
    always_comb begin
        idx      = opt_index(fsel_i);
        kx       = {{(SW-KW){k_i[KW-1]}}, k_i};
        pnx      = $signed({2'b00, pn_arr[idx]});
        stx      = $signed({2'b00, st_arr[idx]});
        sum      = pnx + kx * stx;
        period_o = sum[PW-1:0];
        prod     = PPW'(period_o) * PPW'(DUTY_NUM);
        toff_o   = prod[DUTY_SHIFT +: PW];
    end

endmodule

// File: rtl/swt_cycle.sv
// Switching cycle counter and window decoder.
// It latches the period and the turn-off offset at every cycle start, counts
// through the period, and decodes start, blanking, forced turn-off and the
// duty-limit flag. Assumes the turn-off offset lies beyond the blanking window.
module swt_cycle #(
    parameter int PW      = 14,
    parameter int TON_CYC = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cl_off_i,
    input  logic [PW-1:0] period_i,
    input  logic [PW-1:0] toff_i,
    output logic          run_o,
    output logic          start_o,
    output logic          dutyoff_o,
    output logic          blank_o,
    output logic          dmax_o
);
    logic          run_q;
    logic          on_q;
    logic          flag_q;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] toff_q;
    logic          wrap;

    // Window decodes from the registered count.
    always_comb begin
        start_o   = run_q && (cnt_q == '0);
        blank_o   = run_q && (cnt_q < PW'(TON_CYC));
        dutyoff_o = run_q && on_q && (cnt_q == toff_q);
        wrap      = cnt_q == (per_q - PW'(1));
    end

    // Count through each period, reload at its end, and track the on-time state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            on_q   <= 1'b0;
            flag_q <= 1'b0;
            cnt_q  <= '0;
            per_q  <= '0;
            toff_q <= '0;
        end else if (!en_i) begin
            run_q  <= 1'b0;
            on_q   <= 1'b0;
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!run_q || wrap) begin
            run_q  <= 1'b1;
            on_q   <= 1'b1;
            flag_q <= 1'b0;
            cnt_q  <= '0;
            per_q  <= period_i;
            toff_q <= toff_i;
        end else begin
            cnt_q <= cnt_q + PW'(1);
            if (dutyoff_o) begin
                on_q   <= 1'b0;
                flag_q <= 1'b1;
            end else if (cl_off_i && !blank_o) begin
                on_q <= 1'b0;
            end
        end
    end

    assign run_o  = run_q;
    assign dmax_o = flag_q;

    // R5: the forced turn-off pulse lasts a single clock.
    assert_dutyoff_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dutyoff_o |=> !dutyoff_o);

    // R6: blanking ends exactly TON_CYC clocks into a running period.
    assert_blank_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(blank_o) && run_q) |-> (cnt_q == PW'(TON_CYC)));

    // R9: the flag follows a forced turn-off and is clear at every start.
    assert_flag_after_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dutyoff_o && en_i) |=> dmax_o);
    assert_flag_clear_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !dmax_o);

    // R10: once enable is sampled low, every output is quiet.
    assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!start_o && !blank_o && !dutyoff_o && !dmax_o));

endmodule

// File: rtl/swt_timebase.sv
// Jittered switching timebase, top level.
// It ties the jitter index, the period calculator and the cycle counter
// together. All timing is in system clocks, and the minimum on-time is
// rounded up to whole clocks.
module swt_timebase #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int F_LOW_HZ   = 30_000,
    parameter int JIT_HZ     = 260,
    parameter int JIT_STEPS  = 8,
    parameter int JIT_PCT    = 7,
    parameter int DUTY_NUM   = 96,
    parameter int DUTY_SHIFT = 7,
    parameter int TON_MIN_NS = 360
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fsel_i,
    input  logic       en_i,
    input  logic       cl_off_i,
    output logic       start_o,
    output logic       dutyoff_o,
    output logic       blank_o,
    output logic       dmax_o
);
    localparam int PW      = $clog2(CLK_HZ/F_LOW_HZ + 1) + 1;
    localparam int KW      = $clog2(JIT_STEPS+1) + 1;
    localparam int TON_CYC = (TON_MIN_NS * (CLK_HZ / 1_000_000) + 999) / 1000;

    logic                 run;
    logic signed [KW-1:0] k;
    logic [PW-1:0]        period;
    logic [PW-1:0]        toff;

    swt_jitter #(
        .CLK_HZ   (CLK_HZ),
        .JIT_HZ   (JIT_HZ),
        .JIT_STEPS(JIT_STEPS)
    ) u_jitter (
        .clk  (clk),
        .rst_n(rst_n),
        .run_i(run),
        .k_o  (k)
    );

    swt_period #(
        .CLK_HZ    (CLK_HZ),
        .F_LOW_HZ  (F_LOW_HZ),
        .JIT_STEPS (JIT_STEPS),
        .JIT_PCT   (JIT_PCT),
        .DUTY_NUM  (DUTY_NUM),
        .DUTY_SHIFT(DUTY_SHIFT)
    ) u_period (
        .fsel_i  (fsel_i),
        .k_i     (k),
        .period_o(period),
        .toff_o  (toff)
    );

    swt_cycle #(
        .PW     (PW),
        .TON_CYC(TON_CYC)
    ) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .cl_off_i (cl_off_i),
        .period_i (period),
        .toff_i   (toff),
        .run_o    (run),
        .start_o  (start_o),
        .dutyoff_o(dutyoff_o),
        .blank_o  (blank_o),
        .dmax_o   (dmax_o)
    );

endmodule

// File: tb/tb_swt_timebase.sv
`timescale 1ns/1ps
module tb_swt_timebase;
    localparam int CLK_HZ   = 100_000_000;
    localparam int F_LOW    = 30_000;
    localparam int JIT_HZ   = 2600;
    localparam int S        = 8;
    localparam int PCT      = 7;
    localparam int DNUM     = 96;
    localparam int DSH      = 7;
    localparam int TONNS    = 360;
    localparam int TON_EXP  = (TONNS * (CLK_HZ / 1_000_000) + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n, en, cl_off;
    logic [1:0] fsel;
    logic start_o, dutyoff_o, blank_o, dmax_o;

    always #5 clk = ~clk;

    swt_timebase #(
        .CLK_HZ(CLK_HZ), .F_LOW_HZ(F_LOW), .JIT_HZ(JIT_HZ), .JIT_STEPS(S),
        .JIT_PCT(PCT), .DUTY_NUM(DNUM), .DUTY_SHIFT(DSH), .TON_MIN_NS(TONNS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .fsel_i(fsel), .en_i(en), .cl_off_i(cl_off),
        .start_o(start_o), .dutyoff_o(dutyoff_o), .blank_o(blank_o), .dmax_o(dmax_o)
    );

    int vecs = 0;
    int errs = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int opt(input logic [1:0] s);
        return (s == 2'b11) ? 0 : int'(s);
    endfunction
    function automatic int pn(input logic [1:0] s);
        return CLK_HZ / (F_LOW << opt(s));
    endfunction
    function automatic int stp(input logic [1:0] s);
        return (pn(s) * PCT) / (100 * S);
    endfunction
    function automatic int toff_of(input int p);
        return (p * DNUM) >> DSH;
    endfunction

    // Per-period monitor: records shape of each period, finalised at the next start.
    longint tnow = 0, t0 = 0;
    bit seen = 0;
    int dcnt, dpos, blen, ferr;
    bit bok;
    int p_per, p_dcnt, p_dpos, p_blen, p_ferr;
    bit p_bok;
    int n_fin = 0;

    always @(negedge clk) begin
        int pos;
        bit exp_f;
        tnow++;
        if (!en) seen = 0;
        if (start_o && en) begin
            if (seen) begin
                p_per = int'(tnow - t0); p_dcnt = dcnt; p_dpos = dpos;
                p_blen = blen; p_bok = bok; p_ferr = ferr;
                n_fin++;
            end
            seen = 1; t0 = tnow; dcnt = 0; dpos = 0; blen = 0; bok = 1; ferr = 0;
        end
        if (seen) begin
            pos = int'(tnow - t0);
            if (blank_o) begin
                if (pos != blen) bok = 0;
                blen++;
            end
            exp_f = (dcnt > 0);
            if (dutyoff_o) begin dcnt++; dpos = pos; end
            if (dmax_o != exp_f) ferr++;
        end
    end

    task automatic wait_fin(input int n);
        int tgt;
        tgt = n_fin + n;
        wait (n_fin >= tgt);
    endtask

    task automatic check_shape(input string note);
        chk(p_dcnt == 1, {"R5 pulse count ", note}, p_dcnt, 1);
        chk(p_dpos == toff_of(p_per), {"R5 pulse offset ", note}, p_dpos, toff_of(p_per));
        chk(p_blen == TON_EXP && p_bok, {"R6 blank length ", note}, p_blen, TON_EXP);
        chk(p_ferr == 0, {"R9 flag shape ", note}, p_ferr, 0);
    endtask

    task automatic check_bounds(input logic [1:0] s, input string tag);
        int lo, hi;
        lo = pn(s) - S * stp(s);
        hi = pn(s) + S * stp(s);
        chk(p_per >= lo && p_per <= hi, tag, p_per, pn(s));
    endtask

    task automatic t_reset;
        int bad = 0;
        rst_n = 0; en = 0; cl_off = 0; fsel = 2'b10;
        repeat (5) @(negedge clk);
        if (start_o | dutyoff_o | blank_o | dmax_o) bad++;
        chk(bad == 0, "R1 outputs in reset", bad, 0);
        rst_n = 1;
        repeat (40) @(negedge clk) if (start_o | dutyoff_o | blank_o | dmax_o) bad++;
        chk(bad == 0, "R1 outputs idle while disabled", bad, 0);
    endtask

    task automatic t_enable(input logic [1:0] s, input string tag);
        fsel = s;
        @(negedge clk);
        en = 1;
        @(negedge clk);
        chk(start_o == 1'b1, {tag, " start one clock after enable"}, start_o, 1);
        wait_fin(1);
        chk(p_per == pn(s), {tag, " first period nominal"}, p_per, pn(s));
        check_shape("first period");
    endtask

    task automatic t_plain;
        for (int i = 0; i < 3; i++) begin
            wait_fin(1);
            check_shape("plain");
        end
    endtask

    task automatic t_cl_late;
        wait_fin(1);
        repeat (99) @(negedge clk);
        cl_off = 1;
        @(negedge clk);
        cl_off = 0;
        wait_fin(1);
        chk(p_dcnt == 0, "R7 no forced turn-off after request", p_dcnt, 0);
        chk(p_ferr == 0, "R7 flag low after request", p_ferr, 0);
    endtask

    task automatic t_cl_blank;
        wait_fin(1);
        repeat (10) @(negedge clk);
        cl_off = 1;
        @(negedge clk);
        cl_off = 0;
        wait_fin(1);
        chk(p_dcnt == 1, "R8 request in blanking ignored", p_dcnt, 1);
        chk(p_dpos == toff_of(p_per), "R8 offset kept", p_dpos, toff_of(p_per));
    endtask

    task automatic t_sweep;
        int mn, mx, prev, d;
        mn = 1 << 30; mx = 0;
        wait_fin(1);
        prev = p_per;
        for (int i = 0; i < 100; i++) begin
            wait_fin(1);
            check_bounds(2'b10, "R3 period in swing");
            d = (p_per > prev) ? p_per - prev : prev - p_per;
            chk(d % stp(2'b10) == 0, "R4 change is whole steps", d, 0);
            if (p_per < mn) mn = p_per;
            if (p_per > mx) mx = p_per;
            prev = p_per;
            if (i % 10 == 0) check_shape("sweep");
        end
        chk(mn == pn(2'b10) - S * stp(2'b10), "R4 lowest length reached", mn, pn(2'b10) - S * stp(2'b10));
        chk(mx == pn(2'b10) + S * stp(2'b10), "R4 highest length reached", mx, pn(2'b10) + S * stp(2'b10));
    endtask

    task automatic t_sel(input logic [1:0] from_s, input logic [1:0] to_s, input string tag);
        wait_fin(1);
        repeat (10) @(negedge clk);
        fsel = to_s;
        wait_fin(1);
        check_bounds(from_s, {tag, " running period kept"});
        wait_fin(1);
        check_bounds(to_s, {tag, " new option applied"});
        check_shape(tag);
    endtask

    task automatic t_disable;
        int bad = 0;
        @(negedge clk);
        en = 0;
        repeat (4000) @(negedge clk) if (start_o | dutyoff_o | blank_o | dmax_o) bad++;
        chk(bad == 0, "R10 outputs quiet while disabled", bad, 0);
        t_enable(2'b10, "R10 restart");
    endtask

    initial begin
        #1_900_000;
        errs++;
        vecs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        t_reset();
        t_enable(2'b10, "R2");
        t_plain();
        t_cl_late();
        t_cl_blank();
        t_sweep();
        t_sel(2'b10, 2'b00, "R11 high to low");
        t_sel(2'b00, 2'b11, "R11 reserved code as low");
        t_sel(2'b11, 2'b01, "R11 low to mid");
        t_disable();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule